// File: doc/BRIEF.md
# Shadow-Updated PWM Channel

This block drives one pulse-width-modulated output from a small 32-bit register file. Software programs a period and a duty value, counted in ticks of a prescaled clock, together with two polarity bits that set the output level during the duty part and the level when idle. The period, duty and polarity values sit in shadow storage. The running counter only copies them when software writes a commit bit. The copy happens at the next period boundary, so a period that is already running always ends with the values it started with. When the channel is stopped, a commit takes effect at once.

The enable, clock-control and control registers take masked writes. The upper 16 bits of the write data enable the corresponding lower 16 bits, so software can change one field without reading the register first. The channel runs either continuously or for a single period (oneshot). After a oneshot period it clears its own PWM enable bit and returns to the idle level. An identification register reports a build-time channel count and channel index.

Byte offsets: identification 0x00, enable 0x04, clock control 0x08, control 0x0C, period 0x10, duty 0x14.

Top module: `pwm_chan`

## Requirements
- R1: After reset the registers read: enable 0, clock control 0, control 0x4 (oneshot, duty level high, idle level low), period 0 and duty 0. `pwm_out` is 0.
- R2: The identification register reads NUM_CH in bits 3:0 and CH_IDX in bits 7:4, with all other bits zero.
- R3: A write to enable (0x04), clock control (0x08) or control (0x0C) changes bit n (n < 16) only when bit n+16 of the write is 1. A write with all mask bits 0 leaves the register unchanged.
- R4: Clock control bits 2:0 (prescale) and 12:4 (scale) set the tick length to (scale+1)·2^prescale clocks. Each count of the counter lasts exactly that many clocks.
- R5: In continuous mode (control bits 1:0 = 1), every window of period·N clocks holds exactly min(duty, period)·N clocks at the duty level, where N is the tick length.
- R6: A duty of 0 gives the idle level throughout. A duty at or above the period gives the duty level throughout.
- R7: Writes to period (0x10), duty (0x14) and the control polarity bits are held in shadow storage and read back at once. They do not change the output until a commit.
- R8: Writing 1 to enable bit 2 (with mask bit 18) latches a commit, which reads back as enable bit 2 = 1. At the next period boundary the shadow values load together and the bit reads 0.
- R9: A commit made while the channel is not running loads the shadow values on the next clock.
- R10: Control bit 2 is the output level during the duty part and control bit 3 is the level when idle. Both take effect through a commit.
- R11: In oneshot mode (control bits 1:0 = 0), after enable (bit 0 clock enable, bit 1 PWM enable) the channel runs exactly one period. It then drives the idle level and clears enable bit 1.
- R12: When the clock enable is 0, the PWM enable is 0, or the mode is 2 or 3, the output drives the idle level and the counter holds at zero. A restart therefore begins with a full duty part.
- R13: Enable bit 4 is stored and read back and has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data (value plus mask for control registers) |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
On every cycle the assertions check four things. The counter stays below the active period. The active period, duty and polarity never change inside a running period. A consumed commit clears unless it is re-armed, and a stopped channel holds its counter at zero. They also check that oneshot drops the PWM enable at its boundary and that an unmasked write leaves the clock enable alone. Only the bench scenarios can show the arithmetic of the waveform: duty-level counts for each mix of period, duty and tick length, the extreme duty values, and the oneshot run length. The scenarios also show that shadow writes stay invisible until a commit, the timing of the pending bit, and the inverted polarity.

// File: rtl/pwm_pkg.sv
// Shared offsets, field widths and types of the PWM channel.
package pwm_pkg;
    localparam int OFS_ID   = 0;
    localparam int OFS_EN   = 4;
    localparam int OFS_CLK  = 8;
    localparam int OFS_CTRL = 12;
    localparam int OFS_PER  = 16;
    localparam int OFS_DUTY = 20;

    localparam int PRE_W = 3;
    localparam int SCL_W = 9;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_CONT    = 2'd1,
        MODE_CAPT    = 2'd2,
        MODE_RSVD    = 2'd3
    } mode_e;

    typedef struct packed {
        logic idle_hi;
        logic duty_hi;
    } pol_t;
endpackage

// File: rtl/pwm_regs.sv
// Register file of the PWM channel. Control registers take masked writes
// (upper half enables the lower half bit by bit); period and duty are
// plain 32-bit shadow writes. Holds the commit-pending flag.
// Assumes reg_addr is a byte offset and reads are combinational.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 1,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              oneshot_done,
    input  logic              commit_take,
    output logic              clk_en,
    output logic              pwm_en,
    output mode_e             mode,
    output pol_t              sh_pol,
    output logic [CNT_W-1:0]  sh_period,
    output logic [CNT_W-1:0]  sh_duty,
    output logic [PRE_W-1:0]  prescale,
    output logic [SCL_W-1:0]  scale,
    output logic              commit_pend
);
    logic gjoin_q;
    logic hit_en, hit_clk, hit_ctrl, hit_per, hit_duty;

    // Decode the write target.
    always_comb begin
        hit_en   = reg_wr && (reg_addr == ADDR_W'(OFS_EN));
        hit_clk  = reg_wr && (reg_addr == ADDR_W'(OFS_CLK));
        hit_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
        hit_per  = reg_wr && (reg_addr == ADDR_W'(OFS_PER));
        hit_duty = reg_wr && (reg_addr == ADDR_W'(OFS_DUTY));
    end

    // Register state with masked updates; writes win over self-clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en      <= 1'b0;
            pwm_en      <= 1'b0;
            gjoin_q     <= 1'b0;
            commit_pend <= 1'b0;
            mode        <= MODE_ONESHOT;
            sh_pol      <= '{idle_hi: 1'b0, duty_hi: 1'b1};
            prescale    <= '0;
            scale       <= '0;
            sh_period   <= '0;
            sh_duty     <= '0;
        end else begin
            if (commit_take)  commit_pend <= 1'b0;
            if (oneshot_done) pwm_en      <= 1'b0;
            if (hit_en) begin
                if (reg_wdata[16]) clk_en  <= reg_wdata[0];
                if (reg_wdata[17]) pwm_en  <= reg_wdata[1];
                if (reg_wdata[18] && reg_wdata[2]) commit_pend <= 1'b1;
                if (reg_wdata[20]) gjoin_q <= reg_wdata[4];
            end
            if (hit_clk) begin
                prescale <= (prescale & ~reg_wdata[18:16]) | (reg_wdata[2:0] & reg_wdata[18:16]);
                scale    <= (scale & ~reg_wdata[28:20]) | (reg_wdata[12:4] & reg_wdata[28:20]);
            end
            if (hit_ctrl) begin
                mode <= mode_e'((mode & ~reg_wdata[17:16]) | (reg_wdata[1:0] & reg_wdata[17:16]));
                if (reg_wdata[18]) sh_pol.duty_hi <= reg_wdata[2];
                if (reg_wdata[19]) sh_pol.idle_hi <= reg_wdata[3];
            end
            if (hit_per)  sh_period <= reg_wdata[CNT_W-1:0];
            if (hit_duty) sh_duty   <= reg_wdata[CNT_W-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_W'(OFS_ID):   reg_rdata = {24'b0, 4'(CH_IDX), 4'(NUM_CH)};
            ADDR_W'(OFS_EN):   reg_rdata = {27'b0, gjoin_q, 1'b0, commit_pend, pwm_en, clk_en};
            ADDR_W'(OFS_CLK):  reg_rdata = {19'b0, scale, 1'b0, prescale};
            ADDR_W'(OFS_CTRL): reg_rdata = {28'b0, sh_pol.idle_hi, sh_pol.duty_hi, mode};
            ADDR_W'(OFS_PER):  reg_rdata = 32'(sh_period);
            ADDR_W'(OFS_DUTY): reg_rdata = 32'(sh_duty);
            default:           reg_rdata = 32'b0;
        endcase
    end
endmodule

// File: rtl/pwm_prescaler.sv
// Tick generator: one tick every (scale+1) << prescale clocks while run
// is high; restarts from zero whenever run is low.
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);
    localparam int DIV_W = SCL_W + 1 + (2**PRE_W - 1);

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] div;

    // Division ratio and terminal count.
    always_comb begin
        div  = (DIV_W'(scale) + 1'b1) << prescale;
        tick = run && (pcnt == div - 1'b1);
    end

    // Clock divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) pcnt <= '0;
        else                        pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/pwm_core.sv
// Period counter, active configuration and output stage. The active copy
// loads from shadow on a commit at a period boundary, or at once while the
// channel is stopped. Assumes tick is low whenever run is low.
module pwm_core
    import pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             pwm_en,
    input  mode_e            mode,
    input  pol_t             sh_pol,
    input  logic [CNT_W-1:0] sh_period,
    input  logic [CNT_W-1:0] sh_duty,
    input  logic             commit_pend,
    input  logic             tick,
    output logic             run,
    output logic             bnd,
    output logic             commit_take,
    output logic             oneshot_done,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_period,
    output logic [CNT_W-1:0] act_duty,
    output pol_t             act_pol,
    output logic             pwm_out
);
    logic last;

    // Run state, boundary detection and commit consumption.
    always_comb begin
        run          = clk_en && pwm_en && (mode == MODE_ONESHOT || mode == MODE_CONT);
        last         = (act_period == '0) || (cnt == act_period - 1'b1);
        bnd          = run && tick && last;
        commit_take  = commit_pend && (!run || bnd);
        oneshot_done = bnd && (mode == MODE_ONESHOT);
    end

    // Period counter: held at zero when stopped, wraps at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= bnd ? '0 : cnt + 1'b1;
    end

    // Active configuration, loaded only by a consumed commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= '0;
            act_duty   <= '0;
            act_pol    <= '{idle_hi: 1'b0, duty_hi: 1'b1};
        end else if (commit_take) begin
            act_period <= sh_period;
            act_duty   <= sh_duty;
            act_pol    <= sh_pol;
        end
    end

    // Output level selection.
    always_comb begin
        pwm_out = (run && (cnt < act_duty)) ? act_pol.duty_hi : act_pol.idle_hi;
    end
endmodule

// File: rtl/pwm_chan.sv
// Top of the shadow-updated PWM channel: register file, prescaler and
// counter/output core. Synchronous active-low reset.
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 1,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pwm_out
);
    logic             clk_en, pwm_en, commit_pend, commit_take, oneshot_done;
    logic             run, bnd, tick;
    mode_e            mode;
    pol_t             sh_pol, act_pol;
    logic [CNT_W-1:0] sh_period, sh_duty, act_period, act_duty, cnt;
    logic [PRE_W-1:0] prescale;
    logic [SCL_W-1:0] scale;

    pwm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_CH(NUM_CH), .CH_IDX(CH_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .oneshot_done(oneshot_done), .commit_take(commit_take),
        .clk_en(clk_en), .pwm_en(pwm_en), .mode(mode), .sh_pol(sh_pol),
        .sh_period(sh_period), .sh_duty(sh_duty),
        .prescale(prescale), .scale(scale), .commit_pend(commit_pend)
    );

    pwm_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .run(run),
        .prescale(prescale), .scale(scale), .tick(tick)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pwm_en(pwm_en),
        .mode(mode), .sh_pol(sh_pol), .sh_period(sh_period), .sh_duty(sh_duty),
        .commit_pend(commit_pend), .tick(tick), .run(run), .bnd(bnd),
        .commit_take(commit_take), .oneshot_done(oneshot_done), .cnt(cnt),
        .act_period(act_period), .act_duty(act_duty), .act_pol(act_pol),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
// Assertion checker for pwm_chan, attached by bind.
module pwm_chan_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_wr,
    input logic             wd_clk_mask,
    input logic             wd_commit,
    input logic             clk_en,
    input logic             pwm_en,
    input logic [1:0]       mode,
    input logic             commit_pend,
    input logic             commit_take,
    input logic             bnd,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_period,
    input logic [CNT_W-1:0] act_duty,
    input logic [1:0]       act_pol
);
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_period != '0) |-> (cnt < act_period));

    p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bnd) |=> ($stable(act_period) && $stable(act_duty) && $stable(act_pol)));

    p_commit_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_take |=> (!commit_pend || $past(en_wr && wd_commit)));

    p_idle_counter_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    p_oneshot_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && mode == 2'd0 && !en_wr) |=> !pwm_en);

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !wd_clk_mask) |=> $stable(clk_en));
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .en_wr(reg_wr && (reg_addr == ADDR_W'(pwm_pkg::OFS_EN))),
    .wd_clk_mask(reg_wdata[16]),
    .wd_commit(reg_wdata[18] && reg_wdata[2]),
    .clk_en(clk_en), .pwm_en(pwm_en), .mode(mode),
    .commit_pend(commit_pend), .commit_take(commit_take),
    .bnd(bnd), .run(run), .cnt(cnt),
    .act_period(act_period), .act_duty(act_duty), .act_pol(act_pol)
);

// File: tb/tb_pwm_chan.sv
module tb_pwm_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int nchk = 0;
    int nerr = 0;

    localparam logic [4:0] A_ID = 5'h00, A_EN = 5'h04, A_CLK = 5'h08,
                           A_CTRL = 5'h0C, A_PER = 5'h10, A_DUTY = 5'h14;

    pwm_chan #(.ADDR_W(5), .CNT_W(32), .NUM_CH(3), .CH_IDX(5)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic measure(input int n, input logic lvl, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out === lvl) hits++;
            @(negedge clk);
        end
    endtask

    // Stop, load period/duty/clock, commit while stopped.
    task automatic cfg(input int p, input int d, input int pre, input int scl);
        wr(A_EN, 32'h0003_0000);
        wr(A_CLK, 32'h1FF7_0000 | 32'(pre) | (32'(scl) << 4));
        wr(A_PER, 32'(p));
        wr(A_DUTY, 32'(d));
        wr(A_EN, 32'h0004_0004);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int hits, n, p;
        int pres [4] = '{0, 1, 0, 2};
        int scls [4] = '{0, 0, 2, 1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_EN, v);   chk("R1 enable", v, 32'h0);
        rd(A_CLK, v);  chk("R1 clkctl", v, 32'h0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h4);
        rd(A_PER, v);  chk("R1 period", v, 32'h0);
        rd(A_DUTY, v); chk("R1 duty", v, 32'h0);
        chk("R1 pwm_out", 32'(pwm_out), 32'h0);
        // R2 identification
        rd(A_ID, v);   chk("R2 id", v, 32'h53);

        // continuous mode
        wr(A_CTRL, 32'h0003_0001);

        // R4 R5 R6 R9 sweep over tick length, period and duty
        for (int c = 0; c < 4; c++) begin
            n = (scls[c] + 1) << pres[c];
            for (int pp = 1; pp <= 4; pp++) begin
                for (int dd = 0; dd <= 5; dd++) begin
                    cfg(pp, dd, pres[c], scls[c]);
                    wr(A_EN, 32'h0003_0003);
                    measure(pp * n, 1'b1, hits);
                    chk($sformatf("R4 R5 R6 R9 p=%0d d=%0d n=%0d", pp, dd, n),
                        32'(hits), 32'(((dd < pp) ? dd : pp) * n));
                end
            end
        end

        // R7 shadow writes invisible until commit
        cfg(4, 1, 3, 0);
        wr(A_EN, 32'h0003_0003);
        measure(32, 1'b1, hits); chk("R7 before shadow write", 32'(hits), 32'd8);
        wr(A_DUTY, 32'd3);
        rd(A_DUTY, v); chk("R7 duty readback", v, 32'd3);
        measure(32, 1'b1, hits); chk("R7 no commit no change", 32'(hits), 32'd8);

        // R8 pending commit applies at boundary
        wr(A_EN, 32'h0003_0000);
        wr(A_EN, 32'h0003_0003);
        wr(A_EN, 32'h0004_0004);
        rd(A_EN, v); chk("R8 pending set", v, 32'h7);
        repeat (40) @(negedge clk);
        rd(A_EN, v); chk("R8 pending cleared", v, 32'h3);
        measure(32, 1'b1, hits); chk("R8 new duty active", 32'(hits), 32'd24);

        // R10 inverted polarity
        wr(A_EN, 32'h0003_0000);
        wr(A_CTRL, 32'h000C_0008);
        wr(A_EN, 32'h0004_0004);
        @(negedge clk);
        chk("R10 idle level high", 32'(pwm_out), 32'h1);
        wr(A_EN, 32'h0003_0003);
        measure(32, 1'b0, hits); chk("R10 duty level low", 32'(hits), 32'd24);
        wr(A_EN, 32'h0003_0000);
        wr(A_CTRL, 32'h000C_0004);
        wr(A_EN, 32'h0004_0004);

        // R11 oneshot
        cfg(3, 2, 1, 0);
        wr(A_CTRL, 32'h0003_0000);
        wr(A_EN, 32'h0003_0003);
        measure(16, 1'b1, hits); chk("R11 oneshot duty cycles", 32'(hits), 32'd4);
        rd(A_EN, v); chk("R11 pwm enable cleared", v, 32'h1);
        chk("R11 output idle", 32'(pwm_out), 32'h0);

        // R12 stopped states
        wr(A_CTRL, 32'h0003_0002);
        wr(A_EN, 32'h0003_0003);
        measure(16, 1'b1, hits); chk("R12 capture mode idle", 32'(hits), 32'd0);
        rd(A_EN, v); chk("R12 capture keeps enable", v, 32'h3);
        wr(A_CTRL, 32'h0003_0001);
        wr(A_EN, 32'h0003_0002);
        measure(16, 1'b1, hits); chk("R12 clock enable off idle", 32'(hits), 32'd0);
        wr(A_EN, 32'h0001_0001);
        measure(4, 1'b1, hits); chk("R12 restart full duty", 32'(hits), 32'd4);

        // R13 global join stored only
        wr(A_EN, 32'h0010_0010);
        rd(A_EN, v); chk("R13 join readback", v, 32'h13);
        measure(6, 1'b1, hits); chk("R13 output unchanged", 32'(hits), 32'd4);

        // R3 masked writes
        wr(A_CLK, 32'h0002_0007);
        rd(A_CLK, v); chk("R3 clk partial mask", v, 32'h3);
        wr(A_EN, 32'h0000_0000);
        rd(A_EN, v); chk("R3 enable zero mask", v, 32'h13);
        wr(A_CTRL, 32'h0000_000B);
        rd(A_CTRL, v); chk("R3 ctrl zero mask", v, 32'h5);

        p = 0;
        $display("Result: errors=%0d of %0d checks", nerr, nchk + p);
        $finish;
    end
endmodule